// File: doc/BRIEF.md
# Pipelined Karatsuba Integer Multiplier

This block multiplies two unsigned 32-bit integers and returns the exact 64-bit product. Inside, each operand is cut into a high half and a low half. Three products of half width are formed: the two high halves, the two low halves, and the two half-sums. The final product is assembled from these three with shifts, one subtraction and one addition. The cut is applied again to each of the three sub-products, down to a configurable number of levels. At the bottom an ordinary narrow multiplier does the work.

Every recursion level places registers on both sides of its sub-multipliers. This keeps each combinational stage to a single adder or a narrow multiply. The pipeline takes a new operand pair on every clock cycle and delivers results in the order the pairs went in, after a fixed latency.

Both sides of the block use valid/ready handshakes. When the consumer holds off, the entire pipeline freezes, so the block never drops or duplicates a result.

Top module: `karatsuba_mul`

## Requirements
- R1: For every accepted pair, `outProd` equals the exact unsigned product `inA * inB`, all 64 bits.
- R2: Each recursion level builds its result from exactly three sub-products: high×high, low×low, and (high+low)×(high+low). At every level, the middle sub-product is never smaller than the sum of the other two.
- R3: While `outReady` stays high, a pair accepted on the clock edge of cycle c shows up with `outValid` high in cycle c+8. The latency is 8 cycles with the default two recursion levels.
- R4: When `outValid` is high and `outReady` is low, `outValid` and `outProd` stay unchanged in the next cycle.
- R5: Each accepted pair produces exactly one result. Results come out in acceptance order, with no spurious `outValid`.
- R6: `inReady` is high whenever `outReady` is high or `outValid` is low. Under that condition a new pair is accepted on every cycle.
- R7: While reset is held, and right after it is released, `outValid` is low and `inReady` is high.
- R8: Corner operands give correct products. These are zero, one, all ones, and values whose halves overflow into the extra bit of the half-sums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair present |
| inReady | output | 1 | Block can take an operand pair this cycle |
| inA | input | 32 | First unsigned operand |
| inB | input | 32 | Second unsigned operand |
| outValid | output | 1 | Product present |
| outReady | input | 1 | Consumer takes the product this cycle |
| outProd | output | 64 | Unsigned product |

## Verification
Directed pairs come first. They include zero, one and all-ones operands, and halves chosen so that the 17-bit half-sums carry into their top bit. These separate a correct middle-term subtraction from one that loses the carry or double-counts an outer product. A long run of random pairs follows, with `outReady` held high. It shows that the pipeline takes one pair per cycle and delivers each result after exactly 8 cycles. The last phase randomises both `inValid` and `outReady`, which exposes lost, duplicated or reordered results and any output that changes during a stall.

// File: rtl/km_pkg.sv
package km_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic advance;  // every pipeline register moves one stage
    logic capture;  // operand registers take the new input pair
  } kmStrobes_t;

  // Cycles through one recursion node of the given depth.
  function automatic int unsigned nodeLatency(input int unsigned levels);
    return 1 + 3 * levels;
  endfunction

  // Input capture register plus the full node tree.
  function automatic int unsigned totalLatency(input int unsigned levels);
    return 1 + nodeLatency(levels);
  endfunction

endpackage

// File: rtl/kara_node.sv
module kara_node #(
  parameter int unsigned W      = 32,
  parameter int unsigned LEVELS = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           en,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);

  generate
    if (LEVELS == 0) begin : g_base
      // Leaf: one registered narrow multiply.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)   p <= '0;
        else if (en) p <= {{W{1'b0}}, a} * {{W{1'b0}}, b};
      end
    end else begin : g_split
      localparam int unsigned LO = W / 2;
      localparam int unsigned HI = W - LO;
      localparam int unsigned SW = HI + 1;

      logic [HI-1:0]     aHi, bHi;
      logic [LO-1:0]     aLo, bLo;
      logic [SW-1:0]     aSum, bSum;
      logic [2*HI-1:0]   pHi, hiQ;
      logic [2*LO-1:0]   pLo, loQ;
      logic [2*SW-1:0]   pMid, midQ;
      logic [2*W-1:0]    midWide;

      // Stage 1: split into halves and form the half-sums.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          aHi <= '0; bHi <= '0; aLo <= '0; bLo <= '0;
          aSum <= '0; bSum <= '0;
        end else if (en) begin
          aHi  <= a[W-1:LO];
          bHi  <= b[W-1:LO];
          aLo  <= a[LO-1:0];
          bLo  <= b[LO-1:0];
          aSum <= {1'b0, a[W-1:LO]} + SW'(a[LO-1:0]);
          bSum <= {1'b0, b[W-1:LO]} + SW'(b[LO-1:0]);
        end
      end

      // The three sub-products, one recursion level deeper.
      kara_node #(.W(HI), .LEVELS(LEVELS - 1)) u_hi (
        .clk(clk), .rstN(rstN), .en(en), .a(aHi), .b(bHi), .p(pHi));
      kara_node #(.W(LO), .LEVELS(LEVELS - 1)) u_lo (
        .clk(clk), .rstN(rstN), .en(en), .a(aLo), .b(bLo), .p(pLo));
      kara_node #(.W(SW), .LEVELS(LEVELS - 1)) u_mid (
        .clk(clk), .rstN(rstN), .en(en), .a(aSum), .b(bSum), .p(pMid));

      // Stage 2: middle term without the outer products.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          midQ <= '0; hiQ <= '0; loQ <= '0;
        end else if (en) begin
          midQ <= pMid - (2*SW)'(pHi) - (2*SW)'(pLo);
          hiQ  <= pHi;
          loQ  <= pLo;
        end
      end

      assign midWide = (2*W)'(midQ);

      // Stage 3: {hi,lo} already places PH at 2*LO; add the shifted middle.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)   p <= '0;
        else if (en) p <= {hiQ, loQ} + (midWide << LO);
      end

      // R2: the half-sum product always covers both outer products.
      a_r2_mid_covers: assert property (@(posedge clk) disable iff (!rstN)
        ((2*SW+1)'(pMid) >= (2*SW+1)'(pHi) + (2*SW+1)'(pLo)))
        else $error("R2 middle product below outer sum");
    end
  endgenerate

endmodule

// File: rtl/km_datapath.sv
module km_datapath
  import km_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned LEVELS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  kmStrobes_t         strb,
  input  logic [WIDTH-1:0]   inA,
  input  logic [WIDTH-1:0]   inB,
  output logic [2*WIDTH-1:0] prod
);

  logic [WIDTH-1:0] opA, opB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opA <= '0;
      opB <= '0;
    end else if (strb.capture) begin
      opA <= inA;
      opB <= inB;
    end
  end

  kara_node #(.W(WIDTH), .LEVELS(LEVELS)) u_root (
    .clk(clk), .rstN(rstN), .en(strb.advance), .a(opA), .b(opB), .p(prod));

endmodule

// File: rtl/km_ctrl.sv
module km_ctrl
  import km_pkg::*;
#(
  parameter int unsigned LAT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output kmStrobes_t strb
);

  localparam int unsigned CW = $clog2(LAT + 1) + 1;

  logic [LAT-1:0] vld;
  logic [CW-1:0]  inFlight;

  assign outValid     = vld[LAT-1];
  assign strb.advance = !vld[LAT-1] || outReady;
  assign strb.capture = strb.advance && inValid;
  assign inReady      = strb.advance;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             vld <= '0;
    else if (strb.advance) vld <= {vld[LAT-2:0], inValid};
  end

  // Token count kept independently of the valid shift chain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else inFlight <= inFlight + CW'(strb.capture) - CW'(outValid && outReady);
  end

  // R5: every accepted pair is somewhere in the valid chain.
  a_r5_no_token_loss: assert property (@(posedge clk) disable iff (!rstN)
    (CW'($countones(vld)) == inFlight))
    else $error("R5 token count mismatch");

  // R6: an empty output stage never blocks the input.
  a_r6_ready_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid |-> inReady))
    else $error("R6 input blocked while output empty");

endmodule

// File: rtl/karatsuba_mul.sv
module karatsuba_mul
  import km_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned LEVELS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [WIDTH-1:0]   inA,
  input  logic [WIDTH-1:0]   inB,
  output logic               outValid,
  input  logic               outReady,
  output logic [2*WIDTH-1:0] outProd
);

  localparam int unsigned LAT = totalLatency(LEVELS);

  kmStrobes_t strb;

  km_ctrl #(.LAT(LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strb(strb));

  km_datapath #(.WIDTH(WIDTH), .LEVELS(LEVELS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inA(inA), .inB(inB), .prod(outProd));

  // R4: a refused result holds still.
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady |=> outValid && $stable(outProd)))
    else $error("R4 output changed during stall");

endmodule

// File: tb/tb_karatsuba_mul.sv
module tb_karatsuba_mul;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inA = '0;
  logic [31:0] inB = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] outProd;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  bit latCheck = 1'b0;
  bit prevStall = 1'b0;
  logic [63:0] prevProd = '0;
  bit finished = 1'b0;

  logic [63:0] expQ[$];
  int          cycQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  karatsuba_mul dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inA(inA), .inB(inB), .outValid(outValid), .outReady(outReady),
    .outProd(outProd));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One clock of stimulus and observation, all at the falling edge.
  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                      input bit rdy);
    @(negedge clk);
    cyc++;
    if (prevStall)
      check(outValid === 1'b1 && outProd === prevProd, "R4", "held result",
            outProd, prevProd);
    inValid  = v;
    inA      = a;
    inB      = b;
    outReady = rdy;
    #1;
    if (rdy) check(inReady === 1'b1, "R6", "inReady", 64'(inReady), 64'd1);
    if (outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "spurious result", outProd, 64'd0);
      end else begin
        logic [63:0] e;
        int          c0;
        e  = expQ.pop_front();
        c0 = cycQ.pop_front();
        check(outProd === e, "R1", "product", outProd, e);
        if (latCheck)
          check(cyc - c0 == LAT, "R3", "latency", 64'(cyc - c0), 64'(LAT));
      end
    end
    if (inValid && inReady) begin
      expQ.push_back({32'd0, a} * {32'd0, b});
      cycQ.push_back(cyc);
    end
    prevStall = outValid && !outReady;
    prevProd  = outProd;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R7: reset state.
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R7", "outValid in reset", 64'(outValid), 64'd0);
    check(inReady === 1'b1, "R7", "inReady in reset", 64'(inReady), 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R7", "outValid after reset", 64'(outValid), 64'd0);
    check(inReady === 1'b1, "R7", "inReady after reset", 64'(inReady), 64'd1);

    // R8: corner operands, back to back, latency checked (R3).
    latCheck = 1'b1;
    step(1, 32'h0000_0000, 32'hDEAD_BEEF, 1);
    step(1, 32'h0000_0001, 32'h0000_0001, 1);
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    step(1, 32'hFFFF_FFFF, 32'h0000_0001, 1);
    step(1, 32'hFFFF_FFFF, 32'hFFFF_0000, 1);
    step(1, 32'h0000_FFFF, 32'h0000_FFFF, 1);
    step(1, 32'hFFFF_0000, 32'hFFFF_0000, 1);
    step(1, 32'hFF80_FF80, 32'hFF80_00FF, 1);
    step(1, 32'h8000_0000, 32'h8000_0000, 1);
    step(1, 32'h8080_8080, 32'h7F7F_7F7F, 1);
    step(1, 32'hFFFF_FFFF, 32'h0000_0000, 1);
    repeat (LAT + 2) step(0, 32'd0, 32'd0, 1);

    // R1/R6: streaming random pairs, one per cycle.
    for (int i = 0; i < 400; i++) step(1, $urandom, $urandom, 1);
    // Gapped stream with the output always ready.
    for (int i = 0; i < 200; i++) step(($urandom % 3) != 0, $urandom, $urandom, 1);
    repeat (LAT + 2) step(0, 32'd0, 32'd0, 1);

    // R4/R5: random back-pressure.
    latCheck = 1'b0;
    for (int i = 0; i < 1500; i++)
      step(($urandom % 4) != 0, $urandom, $urandom, ($urandom % 3) != 0);
    // Long stall with a full pipeline.
    for (int i = 0; i < 12; i++) step(1, $urandom, $urandom, 0);
    repeat (LAT + 20) step(0, 32'd0, 32'd0, 1);

    // R5: every accepted pair has been delivered.
    check(expQ.size() == 0, "R5", "results outstanding", 64'(expQ.size()), 64'd0);
    check(outValid === 1'b0, "R5", "outValid after drain", 64'(outValid), 64'd0);
    finish_run();
  end

endmodule